// File: doc/BRIEF.md
# Debug Timestamp Counter

The block keeps a 64-bit timestamp that debug logic attaches to trace events. The count moves on a tick pulse. A select input chooses the source of that pulse. In fast mode the pulse comes from an internal divider on the crystal clock, which fires once per microsecond and adds 1. In slow mode the pulse is an external 32 kHz strobe, already synchronised to the clock, and each strobe adds 31. The count wraps to zero after all ones.

Software reaches the block through a small 32-bit register port. Reads are combinational and writes are single-cycle strobes. Software can:
- stop and restart the count with an enable bit, where each restart zeroes the count;
- stage a new 64-bit value in two shadow words and load it on the fly, after which counting carries on from the loaded value;
- read the count coherently, because a low-word read freezes the high word for the read that follows.

A scratch word and a dummy word round out the map.

A two-state machine carries the enable:
- HALT: the count holds.
- RUN: the count advances on each tick.

Transitions:
- START (HALT to RUN, when enable is written 1): zeroes the count on that edge.
- STOP (RUN to HALT, when enable is written 0): from that edge onward, ticks have no effect.
- Each state stays as it is on every other cycle.

Reset enters RUN.

Top module: `dbgts_top`

## Requirements
- R1: After reset, these registers read as follows:
  - control (offset 0x00) reads 0x00000001;
  - the count low word (offset 0x04) and high word (offset 0x08) read 0;
  - scratch (offset 0x14) reads 0;
  - dummy (offset 0x18) reads 0x0000FFFF.
- R2: With `slow_sel` low and the block running, the count rises by exactly 1 every DIV_CYCLES clock cycles.
- R3: With `slow_sel` high, each clock cycle in which `slow_tick` is high adds 31, and the divider has no effect. With `slow_sel` low, `slow_tick` has no effect.
- R4: The count is 64 bits wide. A carry out of the low word propagates into the high word, and the count wraps to zero after all ones.
- R5: Control bit 0 is the enable.
  - Writing 0 enters HALT, and the count then ignores all ticks.
  - Writing 1 while in HALT zeroes the count on that write.
  - Writing 1 while in RUN leaves the count as it is.
  - Bit 0 reads back the current state (1 = RUN).
- R6: Writes to offsets 0x04 and 0x08 go to shadow words. Writing control bit 1 as 1 copies {shadow high, shadow low} into the count on that write, and counting continues from the loaded value. Control bits 31:1 read as 0.
- R7: A load wins over an increment in the same cycle, and over the START clear in the same cycle.
- R8: A read of offset 0x04 returns the live low word and captures the live high word. A later read of offset 0x08 returns that captured word, even if the count has changed in between.
- R9: Scratch (offset 0x14) and dummy (offset 0x18) each store and return a full 32-bit write.
- R10: Reads of any other byte address return 0, including 0x0C, 0x10, 0x1C and misaligned addresses. Writes to those addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the crystal clock for the divider |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_sel | input | 1 | 1 selects the slow strobe (step 31); 0 selects the divider (step 1) |
| slow_tick | input | 1 | Synchronised one-cycle slow-clock strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of `rd_en`, 0 otherwise |

## Verification
The hardest cases to reach from the ports are the same-cycle collisions: a load landing on the very edge where a tick would also add, and a load arriving together with the START clear. The bench reaches them in slow mode, where it owns the timing of every tick. It raises the strobe in the same cycle as the control write, and it issues the load from HALT. Carry and wrap across 2^32 and 2^64 would take ages to reach by counting, so the bench loads values just below each boundary and then fires a single slow strobe. Coherent reads are tested by reloading the high word between the low-word read and the high-word read.

// File: rtl/dbgts_pkg.sv
package dbgts_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 2 * DATA_W;

    localparam int OFS_CTRL    = 'h00;
    localparam int OFS_CNT_LO  = 'h04;
    localparam int OFS_CNT_HI  = 'h08;
    localparam int OFS_SCRATCH = 'h14;
    localparam int OFS_DUMMY   = 'h18;

    localparam logic [DATA_W-1:0] DUMMY_RST = 32'h0000_FFFF;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_LOAD_BIT = 1;

    typedef enum logic {
        CNT_HALT = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/dbgts_tick.sv
module dbgts_tick #(
    parameter int DIV_CYCLES = 24,
    parameter int SLOW_STEP  = 31,
    parameter int STEP_W     = $clog2(SLOW_STEP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_sel,
    input  logic              slow_tick,
    output logic              tick,
    output logic [STEP_W-1:0] step
);
    localparam int DIV_W = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_CYCLES - 1);

    logic [DIV_W-1:0] div_q;
    logic             div_tick;

    assign div_tick = (div_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        div_q <= DIV_LAST;
        else if (div_tick) div_q <= DIV_LAST;
        else               div_q <= div_q - 1'b1;
    end

    assign tick = slow_sel ? slow_tick : div_tick;
    assign step = slow_sel ? STEP_W'(SLOW_STEP) : STEP_W'(1);

    // R2: the divider pulse is never longer than one cycle
    a_r2_div_single: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && (DIV_CYCLES > 1)) |=> !div_tick);
endmodule

// File: rtl/dbgts_count.sv
module dbgts_count
    import dbgts_pkg::*;
#(
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic              en_wdata,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              tick,
    input  logic [STEP_W-1:0] step,
    output logic [CNT_W-1:0]  cnt,
    output logic              running
);
    cnt_state_e state_q, state_d;
    logic en_req, rise, adv;

    assign en_req  = en_wr ? en_wdata : (state_q == CNT_RUN);
    assign running = (state_q == CNT_RUN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CNT_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        adv     = 1'b0;
        unique case (state_q)
            CNT_HALT: begin
                rise    = en_req;
                state_d = en_req ? CNT_RUN : CNT_HALT;
            end
            CNT_RUN: begin
                adv     = en_req && tick;
                state_d = en_req ? CNT_RUN : CNT_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (load) cnt <= load_val;
        else if (rise) cnt <= '0;
        else if (adv)  cnt <= cnt + CNT_W'(step);
    end

    // R7: a load always lands, whatever else happens in that cycle
    a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
    // R5: the START transition zeroes the count
    a_r5_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_HALT && en_req && !load) |=> cnt == '0);
    // R5: the count holds while halted
    a_r5_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CNT_HALT && !en_req && !load) |=> $stable(cnt));
    // R4: advances by the step, modulo 2^64
    a_r4_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> cnt == $past(cnt) + CNT_W'($past(step)));
endmodule

// File: rtl/dbgts_regs.sv
module dbgts_regs
    import dbgts_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              running,
    output logic              ctrl_wr,
    output logic              ctrl_en,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic [DATA_W-1:0] rdata
);
    logic hit_ctrl, hit_lo, hit_hi, hit_scr, hit_dmy, hit_any;
    logic [DATA_W-1:0] shadow_lo, shadow_hi, scratch_q, dummy_q, hold_hi;

    assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
    assign hit_lo   = (addr == ADDR_W'(OFS_CNT_LO));
    assign hit_hi   = (addr == ADDR_W'(OFS_CNT_HI));
    assign hit_scr  = (addr == ADDR_W'(OFS_SCRATCH));
    assign hit_dmy  = (addr == ADDR_W'(OFS_DUMMY));
    assign hit_any  = hit_ctrl | hit_lo | hit_hi | hit_scr | hit_dmy;

    assign ctrl_wr  = wr_en && hit_ctrl;
    assign ctrl_en  = wdata[CTRL_EN_BIT];
    assign load     = ctrl_wr && wdata[CTRL_LOAD_BIT];
    assign load_val = {shadow_hi, shadow_lo};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_lo <= '0;
            shadow_hi <= '0;
            scratch_q <= '0;
            dummy_q   <= DUMMY_RST;
        end else if (wr_en) begin
            if (hit_lo)  shadow_lo <= wdata;
            if (hit_hi)  shadow_hi <= wdata;
            if (hit_scr) scratch_q <= wdata;
            if (hit_dmy) dummy_q   <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                hold_hi <= '0;
        else if (rd_en && hit_lo)  hold_hi <= cnt[CNT_W-1:DATA_W];
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (hit_ctrl)     rdata = {{(DATA_W-1){1'b0}}, running};
            else if (hit_lo)  rdata = cnt[DATA_W-1:0];
            else if (hit_hi)  rdata = hold_hi;
            else if (hit_scr) rdata = scratch_q;
            else if (hit_dmy) rdata = dummy_q;
        end
    end

    // R8: a low-word read freezes the live high word
    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_lo) |=> hold_hi == $past(cnt[CNT_W-1:DATA_W]));
    // R10: unmapped reads return zero
    a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit_any) |-> rdata == '0);
    // R6: control upper bits read as zero
    a_r6_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && hit_ctrl) |-> rdata[DATA_W-1:1] == '0);
endmodule

// File: rtl/dbgts_top.sv
module dbgts_top
    import dbgts_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DIV_CYCLES = 24,
    parameter int SLOW_STEP  = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_sel,
    input  logic              slow_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);
    localparam int STEP_W = $clog2(SLOW_STEP + 1);

    logic              tick, running, ctrl_wr, ctrl_en, load;
    logic [STEP_W-1:0] step;
    logic [CNT_W-1:0]  cnt, load_val;

    dbgts_tick #(
        .DIV_CYCLES(DIV_CYCLES),
        .SLOW_STEP (SLOW_STEP),
        .STEP_W    (STEP_W)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_sel (slow_sel),
        .slow_tick(slow_tick),
        .tick     (tick),
        .step     (step)
    );

    dbgts_count #(.STEP_W(STEP_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (ctrl_wr),
        .en_wdata(ctrl_en),
        .load    (load),
        .load_val(load_val),
        .tick    (tick),
        .step    (step),
        .cnt     (cnt),
        .running (running)
    );

    dbgts_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .cnt     (cnt),
        .running (running),
        .ctrl_wr (ctrl_wr),
        .ctrl_en (ctrl_en),
        .load    (load),
        .load_val(load_val),
        .rdata   (rdata)
    );
endmodule

// File: tb/tb_dbgts_top.sv
module tb_dbgts_top;
    localparam int DIV = 5;
    localparam int NV  = 13;

    logic        clk = 1'b0, rst_n = 1'b0, slow_sel = 1'b1, slow_tick = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    int total = 0, bad = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    dbgts_top #(.ADDR_W(5), .DIV_CYCLES(DIV), .SLOW_STEP(31)) dut (
        .clk(clk), .rst_n(rst_n), .slow_sel(slow_sel), .slow_tick(slow_tick),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // {is_read, addr, wdata, expected}
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 8'h14, 32'hA5A5_0F0F, 32'h0},
        {1'b1, 8'h14, 32'h0,         32'hA5A5_0F0F},
        {1'b0, 8'h18, 32'h1234_5678, 32'h0},
        {1'b1, 8'h18, 32'h0,         32'h1234_5678},
        {1'b0, 8'h0C, 32'hDEAD_BEEF, 32'h0},
        {1'b0, 8'h10, 32'hCAFE_F00D, 32'h0},
        {1'b1, 8'h0C, 32'h0,         32'h0},
        {1'b1, 8'h10, 32'h0,         32'h0},
        {1'b1, 8'h1C, 32'h0,         32'h0},
        {1'b1, 8'h15, 32'h0,         32'h0},
        {1'b1, 8'h14, 32'h0,         32'hA5A5_0F0F},
        {1'b1, 8'h18, 32'h0,         32'h1234_5678},
        {1'b1, 8'h00, 32'h0,         32'h0000_0001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d, input logic tk);
        addr = a; wdata = d; wr_en = 1'b1; slow_tick = tk;
        @(negedge clk);
        wr_en = 1'b0; slow_tick = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse();
        slow_tick = 1'b1;
        @(negedge clk);
        slow_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic load64(input logic [31:0] hi, input logic [31:0] lo);
        bus_write(5'h04, lo, 1'b0);
        bus_write(5'h08, hi, 1'b0);
        bus_write(5'h00, 32'h3, 1'b0);
    endtask

    initial begin
        logic [31:0] a, b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values (slow mode, no strobes, so the count stays 0)
        bus_read(5'h00, a); check("R1 ctrl", a, 32'h1);
        bus_read(5'h04, a); check("R1 count low", a, 32'h0);
        bus_read(5'h08, a); check("R1 count high", a, 32'h0);
        bus_read(5'h14, a); check("R1 scratch", a, 32'h0);
        bus_read(5'h18, a); check("R1 dummy", a, 32'h0000_FFFF);

        // R9 / R10 vector table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) begin
                bus_read(VEC[i][68:64], a);
                check($sformatf("R9 R10 vector %0d", i), a, VEC[i][31:0]);
            end else begin
                bus_write(VEC[i][68:64], VEC[i][63:32], 1'b0);
            end
        end

        // R2 fast mode: 50 cycles give 10 ticks; slow strobes ignored (R3)
        slow_sel = 1'b0;
        @(negedge clk);
        bus_read(5'h04, a);
        for (int i = 0; i < 49; i++) begin
            slow_tick = (i % 7 == 0);
            @(negedge clk);
        end
        slow_tick = 1'b0;
        bus_read(5'h04, b);
        check("R2 fast tick rate", b - a, 32'd10);

        // R3 slow mode: three strobes, divider ignored
        slow_sel = 1'b1;
        @(negedge clk);
        bus_read(5'h04, a);
        pulse(); pulse(); pulse();
        repeat (60) @(negedge clk);
        bus_read(5'h04, b);
        check("R3 slow step", b - a, 32'd93);

        // R5 halt, START clear, enable while running
        bus_write(5'h00, 32'h0, 1'b0);
        bus_read(5'h00, a); check("R5 ctrl halted", a, 32'h0);
        bus_read(5'h04, a);
        pulse(); pulse();
        bus_read(5'h04, b); check("R5 halted ignores ticks", b, a);
        bus_write(5'h00, 32'h1, 1'b0);
        bus_read(5'h04, a); check("R5 start clears low", a, 32'h0);
        bus_read(5'h08, a); check("R5 start clears high", a, 32'h0);
        pulse();
        bus_write(5'h00, 32'h1, 1'b0);
        bus_read(5'h04, a); check("R5 enable while running keeps count", a, 32'd31);

        // R6 load and continue
        load64(32'hABCD_0001, 32'h1234_5678);
        bus_read(5'h00, a); check("R6 ctrl load bit reads 0", a, 32'h1);
        bus_read(5'h04, a); check("R6 load low", a, 32'h1234_5678);
        bus_read(5'h08, a); check("R6 load high", a, 32'hABCD_0001);
        pulse();
        bus_read(5'h04, a); check("R6 continues after load", a, 32'h1234_5697);

        // R8 coherent read across a high-word change
        bus_read(5'h04, a);
        bus_write(5'h08, 32'h5555_0000, 1'b0);
        bus_write(5'h00, 32'h3, 1'b0);
        bus_read(5'h08, a); check("R8 captured high", a, 32'hABCD_0001);
        bus_read(5'h04, a); check("R8 new low", a, 32'h1234_5678);
        bus_read(5'h08, a); check("R8 new high", a, 32'h5555_0000);

        // R4 carry into high word, then 64-bit wrap
        load64(32'h0000_0007, 32'hFFFF_FFF0);
        pulse();
        bus_read(5'h04, a); check("R4 carry low", a, 32'h0000_000F);
        bus_read(5'h08, a); check("R4 carry high", a, 32'h0000_0008);
        load64(32'hFFFF_FFFF, 32'hFFFF_FFF0);
        pulse();
        bus_read(5'h04, a); check("R4 wrap low", a, 32'h0000_000F);
        bus_read(5'h08, a); check("R4 wrap high", a, 32'h0);

        // R7 load beats a same-cycle tick, and the START clear
        bus_write(5'h04, 32'h0000_0100, 1'b0);
        bus_write(5'h08, 32'h0, 1'b0);
        bus_write(5'h00, 32'h3, 1'b1);
        bus_read(5'h04, a); check("R7 load over tick", a, 32'h0000_0100);
        bus_write(5'h00, 32'h0, 1'b0);
        bus_write(5'h00, 32'h3, 1'b0);
        bus_read(5'h04, a); check("R7 load over start clear", a, 32'h0000_0100);
        bus_read(5'h00, a); check("R7 running after load start", a, 32'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R1 watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule